// File: doc/BRIEF.md
# Decode-Stage Branch Hazard and Forwarding Unit

This block holds the hazard control for a five-stage in-order pipeline that settles equality branches in the Decode stage rather than in Execute. Deciding there shortens the taken-branch penalty to one cycle. The cost is that the two Decode operands may still be in flight. The unit looks at the Decode source register numbers and at the destination, write-enable and load flags of the Execute and Memory stages. From these it chooses whether each comparator operand comes from the register file or from the Memory-stage ALU result. It also compares the two chosen operands and produces the PC redirect. It decides when Fetch and Decode must hold, and which pipeline registers get a bubble.

The unit has no Writeback inputs. The register file is written in the first half of a cycle and read in the second half, so a value that Writeback produces already arrives through the normal read ports. The block is purely combinational. Its outputs feed the enables and clear inputs of the Fetch PC, the Decode register and the Execute register.

Top module: `hz_early_branch`

## Requirements
- R1: `eq_d` is 1 exactly when the two selected comparator operands are equal. Operand A is `alu_out_m` when `fwd_a_d` is 1 and `rd1_d` otherwise. Operand B is `alu_out_m` when `fwd_b_d` is 1 and `rd2_d` otherwise.
- R2: `fwd_a_d` (`fwd_b_d`) is 1 exactly when the Memory-stage instruction writes a register (`wr_m`=1), is not a load (`ld_m`=0), and has `dst_m` equal to a nonzero `rs_d` (`rt_d`). This holds whether or not Decode holds a branch.
- R3: A source register number of 0 never causes forwarding or a stall, whatever the stage destinations are.
- R4: When `br_d`=1 and a nonzero `rs_d` or `rt_d` equals `dst_e` of an instruction with `wr_e`=1, `stall_f`, `stall_d` and `flush_e` are all 1.
- R5: When `br_d`=1 and a nonzero `rs_d` or `rt_d` equals `dst_m` of a load (`ld_m`=1), `stall_f`, `stall_d` and `flush_e` are all 1, and neither forward select is raised for that load.
- R6: When `ld_e`=1 and a nonzero `rs_d` or `rt_d` equals `dst_e`, `stall_f`, `stall_d` and `flush_e` are all 1, whether or not `br_d` is set.
- R7: `pcsrc_d` = `br_d` AND `eq_d` AND NOT `stall_d`. A stalled branch never redirects the PC.
- R8: `flush_d` equals `pcsrc_d`, so the Decode register is cleared on the edge after a taken branch.
- R9: A non-load Execute writer whose destination matches a Decode source causes no stall when `br_d`=0.
- R10: With no dependences (all inputs 0), every stall, flush and forward output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rs_d | input | REG_W | First source register number in Decode |
| rt_d | input | REG_W | Second source register number in Decode |
| br_d | input | 1 | Decode holds an equality branch |
| rd1_d | input | DATA_W | Register-file value for rs_d |
| rd2_d | input | DATA_W | Register-file value for rt_d |
| alu_out_m | input | DATA_W | ALU result held in the Memory stage |
| dst_e | input | REG_W | Destination register number in Execute |
| wr_e | input | 1 | Execute instruction writes a register |
| ld_e | input | 1 | Execute instruction is a load |
| dst_m | input | REG_W | Destination register number in Memory |
| wr_m | input | 1 | Memory instruction writes a register |
| ld_m | input | 1 | Memory instruction is a load |
| fwd_a_d | output | 1 | Comparator operand A taken from alu_out_m |
| fwd_b_d | output | 1 | Comparator operand B taken from alu_out_m |
| eq_d | output | 1 | Selected operands are equal |
| pcsrc_d | output | 1 | Branch taken: load the branch target into the PC |
| stall_f | output | 1 | Hold the PC |
| stall_d | output | 1 | Hold the Decode register |
| flush_d | output | 1 | Clear the Decode register |
| flush_e | output | 1 | Insert a bubble into the Execute register |

## Verification
The unit holds no state, so a wrong internal decision shows at the ports in the same cycle as the input pattern that exposes it. A wrong forward select shows up either as a flipped `eq_d` or as a redirect that should not happen. A missed dependence shows as `stall_d` and `flush_e` staying low, and `pcsrc_d` may rise on stale operands. The vectors use operand values chosen so that a wrong selection changes `eq_d`. This makes a bad mux choice visible at the ports and not hidden behind equal values.

// File: rtl/hz_pkg.sv
// Shared sizes and the forward-select encoding for the early-branch unit.
// Assumes 32 architectural registers and register 0 hard-wired to zero.
package hz_pkg;
    localparam int REG_W_DEF  = 5;
    localparam int DATA_W_DEF = 32;

    // Source of one comparator operand
    typedef enum logic {
        SRC_REGFILE = 1'b0,
        SRC_MEM_ALU = 1'b1
    } opsrc_e;
endpackage

// File: rtl/hz_src_match.sv
// Compares both Decode source numbers against one stage destination.
// Assumes register number 0 is never a real dependence.
module hz_src_match #(
    parameter int REG_W = hz_pkg::REG_W_DEF
) (
    input  logic [REG_W-1:0] rs,
    input  logic [REG_W-1:0] rt,
    input  logic [REG_W-1:0] dst,
    output logic             hit_rs,
    output logic             hit_rt
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    // Raise a hit only for a nonzero source that equals the destination
    always_comb begin
        hit_rs = (rs != ZERO_REG) && (rs == dst);
        hit_rt = (rt != ZERO_REG) && (rt == dst);
    end
endmodule

// File: rtl/hz_branch_cmp.sv
// Selects each comparator operand (register file or Memory ALU result)
// and tests them for equality. Assumes the selects are already qualified.
module hz_branch_cmp #(
    parameter int DATA_W = hz_pkg::DATA_W_DEF,
    parameter int N_OPS  = 2
) (
    input  logic [N_OPS-1:0]             sel,
    input  logic [N_OPS-1:0][DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0]            mem_val,
    output logic                         equal
);
    logic [N_OPS-1:0][DATA_W-1:0] opnd;

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_op
            // Pick the operand source for comparator input i
            always_comb begin
                opnd[i] = (hz_pkg::opsrc_e'(sel[i]) == hz_pkg::SRC_MEM_ALU)
                          ? mem_val : rf_val[i];
            end
        end
    endgenerate

    // Equality of the two selected operands
    always_comb begin
        equal = (opnd[0] == opnd[1]);
    end
endmodule

// File: rtl/hz_stall_ctrl.sv
// Combines the stage matches into stall, flush and redirect controls.
// Assumes a stall always wins over a taken branch.
module hz_stall_ctrl (
    input  logic br,
    input  logic eq,
    input  logic e_hit,
    input  logic m_hit,
    input  logic wr_e,
    input  logic ld_e,
    input  logic ld_m,
    output logic stall,
    output logic flush_dec,
    output logic flush_ex,
    output logic pcsrc
);
    logic load_use;
    logic br_wait_e;
    logic br_wait_m;

    // Classify the three stall causes
    always_comb begin
        load_use  = ld_e & e_hit;
        br_wait_e = br & wr_e & e_hit;
        br_wait_m = br & ld_m & m_hit;
    end

    // Derive hold, bubble and redirect with the stall taking priority
    always_comb begin
        stall     = load_use | br_wait_e | br_wait_m;
        flush_ex  = stall;
        pcsrc     = br & eq & ~stall;
        flush_dec = pcsrc;
    end
endmodule

// File: rtl/hz_early_branch.sv
// Hazard and forwarding control for a Decode-stage equality branch.
// Assumes the register file writes early and reads late in a cycle,
// so Writeback results need no bypass.
module hz_early_branch #(
    parameter int REG_W  = hz_pkg::REG_W_DEF,
    parameter int DATA_W = hz_pkg::DATA_W_DEF
) (
    input  logic [REG_W-1:0]  rs_d,
    input  logic [REG_W-1:0]  rt_d,
    input  logic              br_d,
    input  logic [DATA_W-1:0] rd1_d,
    input  logic [DATA_W-1:0] rd2_d,
    input  logic [DATA_W-1:0] alu_out_m,
    input  logic [REG_W-1:0]  dst_e,
    input  logic              wr_e,
    input  logic              ld_e,
    input  logic [REG_W-1:0]  dst_m,
    input  logic              wr_m,
    input  logic              ld_m,
    output logic              fwd_a_d,
    output logic              fwd_b_d,
    output logic              eq_d,
    output logic              pcsrc_d,
    output logic              stall_f,
    output logic              stall_d,
    output logic              flush_d,
    output logic              flush_e
);
    logic e_rs, e_rt, m_rs, m_rt;
    logic stall;
    logic [1:0]             sel;
    logic [1:0][DATA_W-1:0] rf_val;

    hz_src_match #(.REG_W(REG_W)) u_match_e (
        .rs(rs_d), .rt(rt_d), .dst(dst_e), .hit_rs(e_rs), .hit_rt(e_rt)
    );

    hz_src_match #(.REG_W(REG_W)) u_match_m (
        .rs(rs_d), .rt(rt_d), .dst(dst_m), .hit_rs(m_rs), .hit_rt(m_rt)
    );

    // Forward from Memory only for a non-load register writer
    always_comb begin
        fwd_a_d   = wr_m & ~ld_m & m_rs;
        fwd_b_d   = wr_m & ~ld_m & m_rt;
        sel       = {fwd_b_d, fwd_a_d};
        rf_val[0] = rd1_d;
        rf_val[1] = rd2_d;
    end

    hz_branch_cmp #(.DATA_W(DATA_W), .N_OPS(2)) u_cmp (
        .sel(sel), .rf_val(rf_val), .mem_val(alu_out_m), .equal(eq_d)
    );

    hz_stall_ctrl u_ctrl (
        .br(br_d), .eq(eq_d),
        .e_hit(e_rs | e_rt), .m_hit(m_rs | m_rt),
        .wr_e(wr_e), .ld_e(ld_e), .ld_m(ld_m),
        .stall(stall), .flush_dec(flush_d), .flush_ex(flush_e),
        .pcsrc(pcsrc_d)
    );

    // Fetch holds whenever Decode holds
    always_comb begin
        stall_f = stall;
        stall_d = stall;
    end
endmodule

// File: rtl/hz_early_branch_chk.sv
// Checker for hz_early_branch: relates the port decisions to the inputs.
// The block is combinational, so the checks are immediate assertions.
module hz_early_branch_chk #(
    parameter int REG_W  = 5,
    parameter int DATA_W = 32
) (
    input logic [REG_W-1:0]  rs_d,
    input logic [REG_W-1:0]  rt_d,
    input logic              br_d,
    input logic [DATA_W-1:0] rd1_d,
    input logic [DATA_W-1:0] rd2_d,
    input logic [DATA_W-1:0] alu_out_m,
    input logic [REG_W-1:0]  dst_e,
    input logic              wr_e,
    input logic              ld_e,
    input logic [REG_W-1:0]  dst_m,
    input logic              wr_m,
    input logic              ld_m,
    input logic              fwd_a_d,
    input logic              fwd_b_d,
    input logic              eq_d,
    input logic              pcsrc_d,
    input logic              stall_f,
    input logic              stall_d,
    input logic              flush_d,
    input logic              flush_e
);
    // Check the outputs each time the inputs settle
    always_comb begin
        if (!$isunknown({rs_d, rt_d, br_d, dst_e, wr_e, ld_e, dst_m, wr_m, ld_m})) begin
            AST_NO_REDIRECT_IN_STALL: assert (!(pcsrc_d && stall_d)) else $error("redirect during stall"); // R7
            AST_ZERO_SRC_NO_FWD: assert (!((rs_d == '0) && fwd_a_d) && !((rt_d == '0) && fwd_b_d)) else $error("zero forwarded"); // R3
            AST_LOAD_M_NO_FWD: assert (!(ld_m && (fwd_a_d || fwd_b_d))) else $error("load forwarded"); // R5
            AST_BR_E_DEP_STALLS: assert (!(br_d && wr_e && (((rs_d != '0) && (rs_d == dst_e)) || ((rt_d != '0) && (rt_d == dst_e)))) || (stall_d && flush_e)) else $error("branch E dep missed"); // R4
            AST_FLUSH_D_NEEDS_BR: assert (!flush_d || (br_d && eq_d)) else $error("decode flush without branch"); // R8
        end
    end
endmodule

bind hz_early_branch hz_early_branch_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_hz_early_branch.sv
// Vector-table bench for hz_early_branch, then directed corner cases.
module tb_hz_early_branch;
    localparam int RW = 5;
    localparam int DW = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [RW-1:0] rs_d, rt_d, dst_e, dst_m;
    logic          br_d, wr_e, ld_e, wr_m, ld_m;
    logic [DW-1:0] rd1_d, rd2_d, alu_out_m;
    logic fwd_a_d, fwd_b_d, eq_d, pcsrc_d, stall_f, stall_d, flush_d, flush_e;

    hz_early_branch #(.REG_W(RW), .DATA_W(DW)) dut (.*);

    // exp bits, high to low: fa fb eq pc stall flush_d flush_e
    typedef struct packed {
        logic [RW-1:0] rs, rt;
        logic          br;
        logic [DW-1:0] r1, r2, alu;
        logic [RW-1:0] de;
        logic          we, le;
        logic [RW-1:0] dm;
        logic          wm, lm;
        logic [6:0]    exp;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{5'd1, 5'd2, 1'b1, 32'd5, 32'd5, 32'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 7'b0011010, 8'd7},  // R7 R8 taken
        '{5'd1, 5'd2, 1'b1, 32'd5, 32'd6, 32'd0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 7'b0000000, 8'd1},  // R1 unequal
        '{5'd3, 5'd4, 1'b1, 32'd9, 32'd7, 32'd7, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 1'b0, 7'b1011010, 8'd2},  // R2 fwd A
        '{5'd3, 5'd4, 1'b1, 32'd7, 32'd9, 32'd7, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 7'b0111010, 8'd2},  // R2 fwd B
        '{5'd4, 5'd4, 1'b1, 32'd1, 32'd2, 32'd3, 5'd0, 1'b0, 1'b0, 5'd4, 1'b1, 1'b0, 7'b1111010, 8'd2},  // R2 both
        '{5'd5, 5'd6, 1'b1, 32'd1, 32'd1, 32'd0, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b1, 7'b0010101, 8'd5},  // R5 load in M
        '{5'd7, 5'd8, 1'b1, 32'd2, 32'd2, 32'd0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 7'b0010101, 8'd4},  // R4 writer in E
        '{5'd7, 5'd8, 1'b0, 32'd2, 32'd2, 32'd0, 5'd8, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 7'b0010000, 8'd9},  // R9 no branch
        '{5'd7, 5'd8, 1'b0, 32'd1, 32'd2, 32'd0, 5'd7, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 7'b0000101, 8'd6},  // R6 load-use
        '{5'd0, 5'd0, 1'b1, 32'd0, 32'd0, 32'd5, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 7'b0011010, 8'd3},  // R3 zero regs
        '{5'd2, 5'd9, 1'b0, 32'd3, 32'd4, 32'd4, 5'd0, 1'b0, 1'b0, 5'd2, 1'b1, 1'b0, 7'b1010000, 8'd2},  // R2 no branch
        '{5'd3, 5'd4, 1'b1, 32'd5, 32'd5, 32'd6, 5'd0, 1'b0, 1'b0, 5'd3, 1'b1, 1'b0, 7'b1000000, 8'd1}   // R1 fwd breaks eq
    };

    int n_chk  = 0;
    int n_fail = 0;

    task automatic apply(input vec_t v);
        @(posedge clk);
        rs_d = v.rs; rt_d = v.rt; br_d = v.br;
        rd1_d = v.r1; rd2_d = v.r2; alu_out_m = v.alu;
        dst_e = v.de; wr_e = v.we; ld_e = v.le;
        dst_m = v.dm; wr_m = v.wm; ld_m = v.lm;
        @(negedge clk);
        check(v.exp, v.req);
    endtask

    task automatic check(input logic [6:0] exp, input logic [7:0] req);
        logic [6:0] got;
        got = {fwd_a_d, fwd_b_d, eq_d, pcsrc_d, stall_d, flush_d, flush_e};
        n_chk++;
        if (got !== exp || stall_f !== stall_d) begin
            n_fail++;
            $display("FAIL R%0d: got %b (stall_f %b) expected %b", req, got, stall_f, exp);
        end
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        vec_t v;
        // R10: quiet start, all inputs 0
        v = '0;
        v.exp = 7'b0010000;
        v.req = 8'd10;
        apply(v);

        for (int i = 0; i < NV; i++) apply(VECS[i]);

        // R4 with R2: rs forwarded from M, rt waits on an E writer
        v = '0;
        v.rs = 5'd3; v.rt = 5'd6; v.br = 1'b1;
        v.r1 = 32'd9; v.r2 = 32'd1; v.alu = 32'd1;
        v.dm = 5'd3; v.wm = 1'b1; v.de = 5'd6; v.we = 1'b1;
        v.exp = 7'b1010101; v.req = 8'd4;
        apply(v);

        // R3: load in E to r0 with rt=0 gives no stall
        v = '0;
        v.rs = 5'd0; v.rt = 5'd0; v.br = 1'b0;
        v.de = 5'd0; v.we = 1'b1; v.le = 1'b1;
        v.r1 = 32'd1; v.r2 = 32'd2;
        v.exp = 7'b0000000; v.req = 8'd3;
        apply(v);

        // R5: load in M matching rt, values would compare equal
        v = '0;
        v.rs = 5'd1; v.rt = 5'd2; v.br = 1'b1;
        v.r1 = 32'd4; v.r2 = 32'd4;
        v.dm = 5'd2; v.wm = 1'b1; v.lm = 1'b1;
        v.exp = 7'b0010101; v.req = 8'd5;
        apply(v);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule